// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a short-descriptor translation table stored in memory. A requester presents the virtual address, the base of the first-level table, a 3-bit table-size value and a flag saying whether the size limit applies, for the lower table only. The walker then reads one or two words through a simple request/valid memory port. It classifies each descriptor it reads and returns the physical address, the mapping granularity, the shareable, cacheable and bufferable bits, four permission flags and a fault flag.

Four mapping sizes are handled: 16MB supersections and 1MB sections come from the first level, and 64KB large pages and 4KB small pages come from a second-level table of 256 words. The walker takes one request at a time. It shows `busy` while a walk is in flight and raises `done` for exactly one cycle when the result outputs are valid. The result outputs hold their values until the next walk finishes.

Top module: `tw_walker`

## Requirements
- R1: After reset the walker is idle: `done`, `busy` and `mem_req` are all 0.
- R2: The first-level index is VA[31:20] and the first read goes to `req_base + 4*index`. When `req_lower` is 1 and the index is greater than `12'hFFF >> req_size`, the walk ends with `rsp_fault`=1 and no memory read is made.
- R3: A first-level descriptor whose bits[1:0] are 00 ends the walk with `rsp_fault`=1 after exactly one read.
- R4: A first-level descriptor with bit1=1 and bit18=0 is a 1MB section. The result is PA = {desc[31:20], VA[19:0]}, granularity code 2, one read.
- R5: A first-level descriptor with bit1=1 and bit18=1 is a 16MB supersection. The result is PA = {desc[31:24], VA[23:0]}, granularity code 3, one read.
- R6: A first-level descriptor with bits[1:0]=01 points to a second-level table. The second read goes to {desc[31:10], VA[19:12], 2'b00}. If that second descriptor has bits[1:0]=00, the walk ends with a fault after two reads.
- R7: A second-level descriptor with bits[1:0]=01 is a 64KB large page. The result is PA = {desc[31:16], VA[15:0]}, granularity code 1.
- R8: A second-level descriptor with bit1=1 is a 4KB small page. The result is PA = {desc[31:12], VA[11:0]}, granularity code 0, after exactly two reads.
- R9: Attribute bits are taken from the descriptor that ends the walk. At the first level, cacheable is bit 3, bufferable is bit 2 and shareable is bit 16. At the second level, cacheable is bit 3, bufferable is bit 2 and shareable is bit 10.
- R10: Permissions come from a 2-bit access field (first level bits 11:10, second level bits 5:4) and a write-disable bit (first level bit 15, second level bit 9). Field 00 grants nothing. Field 01 grants privileged read and write. Field 10 adds unprivileged read. Field 11 adds unprivileged write. A set write-disable bit clears both write flags.
- R11: Once `mem_req` rises, it stays high with `mem_addr` unchanged until the cycle in which `mem_rvalid` is 1.
- R12: `done` is high for a single cycle per walk. A request presented while `busy` is 1 is ignored. On a fault, the address, granularity, attribute and permission outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Physical base of the first-level table |
| req_size | input | 3 | Table-size value N |
| req_lower | input | 1 | 1 = the size limit applies to this walk |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Word read request, held until answered |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data valid, ends the current read |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Translation fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_gran | output | 2 | 0=4KB, 1=64KB, 2=1MB, 3=16MB |
| rsp_share | output | 1 | Shareable |
| rsp_cache | output | 1 | Cacheable |
| rsp_buffer | output | 1 | Bufferable |
| rsp_priv_rd | output | 1 | Privileged read allowed |
| rsp_priv_wr | output | 1 | Privileged write allowed |
| rsp_user_rd | output | 1 | Unprivileged read allowed |
| rsp_user_wr | output | 1 | Unprivileged write allowed |

## Verification
The bench builds the walker with its default 12-bit first-level index and 8-bit second-level index. At these widths the full 4096-entry index space is reachable, including the exact limit edge for each size value (for example index 0x1FF passes and 0x200 faults at N=3). The second-level address formed from VA[19:12] is exercised over its whole range. The memory model answers after a random delay of zero to two cycles, so both the immediate response and the held-request path are used for first-level and second-level reads.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int VA_W     = 32;
    localparam int L1_IDX_W = 12;
    localparam int L2_IDX_W = 8;
    localparam int SIZE_W   = 3;

    localparam int SECT_SHIFT  = VA_W - L1_IDX_W;          // 20
    localparam int SUPER_SHIFT = SECT_SHIFT + 4;           // 24
    localparam int SMALL_SHIFT = SECT_SHIFT - L2_IDX_W;    // 12
    localparam int LARGE_SHIFT = SMALL_SHIFT + 4;          // 16
    localparam int L2_BASE_LSB = L2_IDX_W + 2;             // 10
    localparam int SUPER_FLAG  = 18;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        GR_4K = 2'd0, GR_64K = 2'd1, GR_1M = 2'd2, GR_16M = 2'd3
    } gran_e;

    typedef enum logic [1:0] {
        K1_FAULT, K1_SECT, K1_SUPER, K1_TABLE
    } l1_kind_e;

    typedef enum logic [1:0] {
        K2_FAULT, K2_LARGE, K2_SMALL
    } l2_kind_e;

    typedef struct packed {
        logic       share;
        logic       cache;
        logic       buffer;
        logic       wr_off;
        logic [1:0] acc;
    } raw_attr_t;

    typedef struct packed {
        logic pr;
        logic pw;
        logic ur;
        logic uw;
    } perm_t;

    function automatic logic [L1_IDX_W-1:0] l1_index_limit(input logic [SIZE_W-1:0] n);
        logic [L1_IDX_W-1:0] all_ones;
        all_ones = '1;
        return all_ones >> n;
    endfunction

    function automatic perm_t decode_perm(input raw_attr_t a);
        perm_t p;
        p.pr = (a.acc != 2'b00);
        p.pw = p.pr && !a.wr_off;
        p.ur = a.acc[1];
        p.uw = (a.acc == 2'b11) && !a.wr_off;
        return p;
    endfunction

endpackage

// File: rtl/tw_l1_class.sv
module tw_l1_class
    import tw_pkg::*;
(
    input  logic [VA_W-1:0]  desc,
    output l1_kind_e         kind
);
    always_comb begin
        if (desc[1:0] == 2'b00)
            kind = K1_FAULT;
        else if (desc[1])
            kind = desc[SUPER_FLAG] ? K1_SUPER : K1_SECT;
        else
            kind = K1_TABLE;
    end
endmodule

// File: rtl/tw_l2_class.sv
module tw_l2_class
    import tw_pkg::*;
(
    input  logic [VA_W-1:0]  desc,
    output l2_kind_e         kind
);
    always_comb begin
        unique case (desc[1:0])
            2'b00:   kind = K2_FAULT;
            2'b01:   kind = K2_LARGE;
            default: kind = K2_SMALL;
        endcase
    end
endmodule

// File: rtl/tw_attr_extract.sv
module tw_attr_extract
    import tw_pkg::*;
#(
    parameter bit SECOND_LEVEL = 1'b0
) (
    input  logic [VA_W-1:0]  desc,
    output raw_attr_t        attr
);
    generate
        if (SECOND_LEVEL) begin : g_lvl2
            always_comb begin
                attr.share  = desc[10];
                attr.cache  = desc[3];
                attr.buffer = desc[2];
                attr.wr_off = desc[9];
                attr.acc    = desc[5:4];
            end
        end else begin : g_lvl1
            always_comb begin
                attr.share  = desc[16];
                attr.cache  = desc[3];
                attr.buffer = desc[2];
                attr.wr_off = desc[15];
                attr.acc    = desc[11:10];
            end
        end
    endgenerate
endmodule

// File: rtl/tw_walker.sv
module tw_walker
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [VA_W-1:0]   req_base,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_lower,
    output logic              busy,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [VA_W-1:0]   mem_rdata,
    output logic              done,
    output logic              rsp_fault,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_gran,
    output logic              rsp_share,
    output logic              rsp_cache,
    output logic              rsp_buffer,
    output logic              rsp_priv_rd,
    output logic              rsp_priv_wr,
    output logic              rsp_user_rd,
    output logic              rsp_user_wr
);
    walk_state_e          state_q;
    logic [VA_W-1:0]      va_q;
    logic [VA_W-1:0]      addr_q;
    logic [VA_W-1:0]      pa_q;
    gran_e                gran_q;
    raw_attr_t            attr_q;
    perm_t                perm_q;
    logic                 fault_q;
    logic [1:0]           rd_cnt_q;

    l1_kind_e             k1;
    l2_kind_e             k2;
    raw_attr_t            a1, a2, a_sel;
    perm_t                p_sel;
    logic                 in_l1, in_l2;
    logic [L1_IDX_W-1:0]  req_idx;
    logic [VA_W-1:0]      l1_addr, l2_addr;

    tw_l1_class u_l1_class (.desc(mem_rdata), .kind(k1));
    tw_l2_class u_l2_class (.desc(mem_rdata), .kind(k2));
    tw_attr_extract #(.SECOND_LEVEL(1'b0)) u_attr1 (.desc(mem_rdata), .attr(a1));
    tw_attr_extract #(.SECOND_LEVEL(1'b1)) u_attr2 (.desc(mem_rdata), .attr(a2));

    assign in_l1   = (state_q == ST_L1_REQ) || (state_q == ST_L1_WAIT);
    assign in_l2   = (state_q == ST_L2_REQ) || (state_q == ST_L2_WAIT);
    assign req_idx = req_vaddr[VA_W-1 -: L1_IDX_W];
    assign l1_addr = req_base + {{(VA_W-L1_IDX_W-2){1'b0}}, req_idx, 2'b00};
    assign l2_addr = {mem_rdata[VA_W-1:L2_BASE_LSB],
                      va_q[SECT_SHIFT-1:SMALL_SHIFT], 2'b00};

    always_comb begin
        a_sel = in_l2 ? a2 : a1;
        p_sel = decode_perm(a_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            va_q     <= '0;
            addr_q   <= '0;
            pa_q     <= '0;
            gran_q   <= GR_4K;
            attr_q   <= '0;
            perm_q   <= '0;
            fault_q  <= 1'b0;
            rd_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q     <= req_vaddr;
                        rd_cnt_q <= '0;
                        if (req_lower && (req_idx > l1_index_limit(req_size))) begin
                            fault_q <= 1'b1;
                            pa_q    <= '0;
                            gran_q  <= GR_4K;
                            attr_q  <= '0;
                            perm_q  <= '0;
                            state_q <= ST_DONE;
                        end else begin
                            addr_q  <= l1_addr;
                            state_q <= ST_L1_REQ;
                        end
                    end
                end
                ST_L1_REQ, ST_L1_WAIT: begin
                    if (mem_rvalid) begin
                        rd_cnt_q <= rd_cnt_q + 2'd1;
                        unique case (k1)
                            K1_FAULT: begin
                                fault_q <= 1'b1;
                                pa_q    <= '0;
                                gran_q  <= GR_4K;
                                attr_q  <= '0;
                                perm_q  <= '0;
                                state_q <= ST_DONE;
                            end
                            K1_SECT: begin
                                fault_q <= 1'b0;
                                pa_q    <= {mem_rdata[VA_W-1:SECT_SHIFT], va_q[SECT_SHIFT-1:0]};
                                gran_q  <= GR_1M;
                                attr_q  <= a_sel;
                                perm_q  <= p_sel;
                                state_q <= ST_DONE;
                            end
                            K1_SUPER: begin
                                fault_q <= 1'b0;
                                pa_q    <= {mem_rdata[VA_W-1:SUPER_SHIFT], va_q[SUPER_SHIFT-1:0]};
                                gran_q  <= GR_16M;
                                attr_q  <= a_sel;
                                perm_q  <= p_sel;
                                state_q <= ST_DONE;
                            end
                            default: begin
                                addr_q  <= l2_addr;
                                state_q <= ST_L2_REQ;
                            end
                        endcase
                    end else if (state_q == ST_L1_REQ) begin
                        state_q <= ST_L1_WAIT;
                    end
                end
                ST_L2_REQ, ST_L2_WAIT: begin
                    if (mem_rvalid) begin
                        rd_cnt_q <= rd_cnt_q + 2'd1;
                        state_q  <= ST_DONE;
                        unique case (k2)
                            K2_FAULT: begin
                                fault_q <= 1'b1;
                                pa_q    <= '0;
                                gran_q  <= GR_4K;
                                attr_q  <= '0;
                                perm_q  <= '0;
                            end
                            K2_LARGE: begin
                                fault_q <= 1'b0;
                                pa_q    <= {mem_rdata[VA_W-1:LARGE_SHIFT], va_q[LARGE_SHIFT-1:0]};
                                gran_q  <= GR_64K;
                                attr_q  <= a_sel;
                                perm_q  <= p_sel;
                            end
                            default: begin
                                fault_q <= 1'b0;
                                pa_q    <= {mem_rdata[VA_W-1:SMALL_SHIFT], va_q[SMALL_SHIFT-1:0]};
                                gran_q  <= GR_4K;
                                attr_q  <= a_sel;
                                perm_q  <= p_sel;
                            end
                        endcase
                    end else if (state_q == ST_L2_REQ) begin
                        state_q <= ST_L2_WAIT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign mem_req     = in_l1 || in_l2;
    assign mem_addr    = addr_q;
    assign done        = (state_q == ST_DONE);
    assign rsp_fault   = fault_q;
    assign rsp_paddr   = pa_q;
    assign rsp_gran    = gran_q;
    assign rsp_share   = attr_q.share;
    assign rsp_cache   = attr_q.cache;
    assign rsp_buffer  = attr_q.buffer;
    assign rsp_priv_rd = perm_q.pr;
    assign rsp_priv_wr = perm_q.pw;
    assign rsp_user_rd = perm_q.ur;
    assign rsp_user_wr = perm_q.uw;

    // read is held with a stable address until answered
    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_fault_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_fault) |-> (rsp_paddr == '0 && !rsp_priv_rd && !rsp_user_rd
                                 && !rsp_share && rsp_gran == 2'd0));

    assert_one_read_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !rsp_fault && rsp_gran[1]) |-> (rd_cnt_q == 2'd1));

    assert_two_reads_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !rsp_fault && !rsp_gran[1]) |-> (rd_cnt_q == 2'd2));

    assert_no_read_fault_R2: assert property (@(posedge clk) disable iff (rst)
        (done && rd_cnt_q == 2'd0) |-> rsp_fault);

    assert_perm_order_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> ((!rsp_priv_wr || rsp_priv_rd) && (!rsp_user_wr || (rsp_user_rd && rsp_priv_wr))));

    assert_busy_idle_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
endmodule

// File: tb/test_tw_walker.sv
`timescale 1ns/1ps
module test_tw_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_base = '0;
    logic [2:0]  req_size = '0;
    logic        req_lower = 1'b0;
    logic        busy, mem_req, done;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_fault, rsp_share, rsp_cache, rsp_buffer;
    logic        rsp_priv_rd, rsp_priv_wr, rsp_user_rd, rsp_user_wr;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_gran;

    always #2.5 clk = ~clk;

    tw_walker i_tw_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_base(req_base), .req_size(req_size), .req_lower(req_lower),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_gran(rsp_gran),
        .rsp_share(rsp_share), .rsp_cache(rsp_cache), .rsp_buffer(rsp_buffer),
        .rsp_priv_rd(rsp_priv_rd), .rsp_priv_wr(rsp_priv_wr),
        .rsp_user_rd(rsp_user_rd), .rsp_user_wr(rsp_user_wr)
    );

    int total = 0;
    int bad   = 0;

    function automatic void chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // ---------------- memory model ----------------
    logic [31:0] mem [int unsigned];
    int          dly = 0;
    bit          pend = 0;
    logic [31:0] pend_addr = '0;
    int          rd_n = 0;
    logic [31:0] rd_addr [2];

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            mem_rvalid = 1'b0;
            pend = 0;
        end else if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            pend = 0;
            dly = $urandom % 3;
        end else if (mem_req) begin
            if (pend) chk(mem_addr == pend_addr, "R11", "held address", mem_addr, pend_addr);
            pend = 1;
            pend_addr = mem_addr;
            if (dly == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(mem_addr);
                if (rd_n < 2) rd_addr[rd_n] = mem_addr;
                rd_n++;
            end else begin
                dly--;
            end
        end else if (pend) begin
            chk(1'b0, "R11", "request dropped", 0, 1);
            pend = 0;
        end
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit          fault;
        logic [31:0] pa;
        logic [1:0]  gran;
        logic [2:0]  scb;
        logic [3:0]  perm;
        int          reads;
        logic [31:0] a1, a2;
        string       tag;
    } exp_t;

    function automatic logic [3:0] perm_of(logic [1:0] acc, bit wd);
        bit pr, pw, ur, uw;
        pr = (acc != 2'b00);
        pw = pr && !wd;
        ur = (acc == 2'b10) || (acc == 2'b11);
        uw = (acc == 2'b11) && !wd;
        return {pr, pw, ur, uw};
    endfunction

    function automatic exp_t model(logic [31:0] va, logic [31:0] base, bit lower, logic [2:0] n);
        exp_t e;
        logic [31:0] d, d2;
        logic [11:0] idx;
        e.fault = 0; e.pa = 0; e.gran = 0; e.scb = 0; e.perm = 0; e.reads = 0;
        e.a1 = 0; e.a2 = 0; e.tag = "R2";
        idx = va[31:20];
        if (lower && idx > (12'hFFF >> n)) begin
            e.fault = 1;
            return e;
        end
        e.a1 = base + {18'd0, idx, 2'b00};
        e.reads = 1;
        d = rd(e.a1);
        if (d[1:0] == 2'b00) begin
            e.fault = 1; e.tag = "R3";
        end else if (d[1] && !d[18]) begin
            e.tag = "R4"; e.pa = {d[31:20], va[19:0]}; e.gran = 2;
            e.scb = {d[16], d[3], d[2]}; e.perm = perm_of(d[11:10], d[15]);
        end else if (d[1]) begin
            e.tag = "R5"; e.pa = {d[31:24], va[23:0]}; e.gran = 3;
            e.scb = {d[16], d[3], d[2]}; e.perm = perm_of(d[11:10], d[15]);
        end else begin
            e.a2 = {d[31:10], va[19:12], 2'b00};
            e.reads = 2;
            d2 = rd(e.a2);
            if (d2[1:0] == 2'b00) begin
                e.fault = 1; e.tag = "R6";
            end else begin
                if (d2[1:0] == 2'b01) begin
                    e.tag = "R7"; e.pa = {d2[31:16], va[15:0]}; e.gran = 1;
                end else begin
                    e.tag = "R8"; e.pa = {d2[31:12], va[11:0]}; e.gran = 0;
                end
                e.scb = {d2[10], d2[3], d2[2]}; e.perm = perm_of(d2[5:4], d2[9]);
            end
        end
        return e;
    endfunction

    // ---------------- walk driver ----------------
    task automatic walk(logic [31:0] va, logic [31:0] base, bit lower, logic [2:0] n, bit poke);
        exp_t e;
        int guard;
        e = model(va, base, lower, n);
        @(negedge clk);
        rd_n = 0;
        req_vaddr = va; req_base = base; req_lower = lower; req_size = n;
        req_valid = 1'b1;
        guard = 0;
        @(negedge clk);
        if (poke) begin
            req_vaddr = va ^ 32'h0FF0_0000;
            req_lower = 1'b0;
        end else begin
            req_valid = 1'b0;
        end
        while (!done && guard < 50) begin
            @(negedge clk);
            req_valid = 1'b0;
            guard++;
        end
        req_valid = 1'b0;
        chk(done, e.tag, "done seen", done, 1);
        chk(rsp_fault == e.fault, e.tag, "fault", rsp_fault, e.fault);
        chk(rsp_paddr == e.pa, e.fault ? "R12" : e.tag, "paddr", rsp_paddr, e.pa);
        chk(rsp_gran == e.gran, e.tag, "gran", rsp_gran, e.gran);
        chk({rsp_share, rsp_cache, rsp_buffer} == e.scb, "R9", "attrs",
            {rsp_share, rsp_cache, rsp_buffer}, e.scb);
        chk({rsp_priv_rd, rsp_priv_wr, rsp_user_rd, rsp_user_wr} == e.perm, "R10", "perm",
            {rsp_priv_rd, rsp_priv_wr, rsp_user_rd, rsp_user_wr}, e.perm);
        chk(rd_n == e.reads, poke ? "R12" : e.tag, "read count", rd_n, e.reads);
        if (e.reads >= 1) chk(rd_addr[0] == e.a1, "R2", "L1 address", rd_addr[0], e.a1);
        if (e.reads == 2) chk(rd_addr[1] == e.a2, "R6", "L2 address", rd_addr[1], e.a2);
        @(negedge clk);
        chk(!done, "R12", "done pulse width", done, 0);
    endtask

    function automatic logic [31:0] rand_l1(int t);
        logic [31:0] r;
        r = $urandom;
        case (t)
            0: r[1:0] = 2'b00;
            1: begin r[1] = 1'b1; r[18] = 1'b0; end
            2: begin r[1] = 1'b1; r[18] = 1'b1; end
            default: r[1:0] = 2'b01;
        endcase
        return r;
    endfunction

    task automatic setup_rand(logic [31:0] va, logic [31:0] base);
        logic [31:0] d, d2, a1, a2;
        int t2;
        a1 = base + {18'd0, va[31:20], 2'b00};
        d = rand_l1($urandom % 4);
        mem[a1] = d;
        if (d[1:0] == 2'b01) begin
            a2 = {d[31:10], va[19:12], 2'b00};
            d2 = $urandom;
            t2 = $urandom % 5;
            if (t2 == 0) d2[1:0] = 2'b00;
            else if (t2 == 1) d2[1:0] = 2'b01;
            else d2[1] = 1'b1;
            mem[a2] = d2;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] va, base;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !busy && !mem_req, "R1", "idle after reset", {done, busy, mem_req}, 0);

        // limit boundary, N=3: index 0x1FF allowed, 0x200 faults without a read
        base = 32'h0004_0000;
        mem.delete();
        mem[base + 32'h1FF*4] = 32'h1230_0C02;
        mem[base + 32'h200*4] = 32'h4560_0C02;
        walk(32'h1FF1_2345, base, 1'b1, 3'd3, 1'b0);
        walk(32'h2001_2345, base, 1'b1, 3'd3, 1'b0);
        // size limit ignored for the upper table
        mem[base + 32'hFFF*4] = 32'hABC0_0C02;
        walk(32'hFFF0_0010, base, 1'b0, 3'd7, 1'b0);
        walk(32'hFFF0_0010, base, 1'b1, 3'd0, 1'b0);
        walk(32'hFFF0_0010, base, 1'b1, 3'd7, 1'b0);
        // empty first-level slot
        walk(32'h0050_0000, base, 1'b0, 3'd0, 1'b0);

        // every permission encoding at both levels (R10)
        for (int k = 0; k < 8; k++) begin
            logic [31:0] d;
            mem.delete();
            d = 32'h0010_0002;
            d[11:10] = k[1:0];
            d[15] = k[2];
            d[16] = k[0];
            mem[base + 32'h3*4] = d;
            walk(32'h0031_1111, base, 1'b0, 3'd0, 1'b0);
            d = 32'h0080_0401;
            mem[base + 32'h4*4] = d;
            mem[{d[31:10], 8'h22, 2'b00}] = {20'hFEDCB, 1'b0, k[2], k[0], 3'b000, k[1:0], 4'b1110};
            walk(32'h0042_2abc, base, 1'b0, 3'd0, 1'b0);
        end

        // supersection and large page directed, with a busy poke (R12)
        mem.delete();
        mem[base + 32'h010*4] = 32'h7F04_8006;
        walk(32'h0105_4321, base, 1'b0, 3'd0, 1'b1);
        mem[base + 32'h020*4] = 32'h0090_0001;
        mem[{22'h0090_00 >> 0, 8'h00, 2'b00} | 32'h0] = 32'h0;
        mem[{32'h0090_0000 | 32'h0}] = 32'h0;
        mem[32'h0090_0000 + 32'h33*4] = 32'h5555_0435;
        walk(32'h0203_3789, base, 1'b0, 3'd0, 1'b1);

        // constrained random walks
        for (int i = 0; i < 160; i++) begin
            mem.delete();
            base = {$urandom} & 32'hFFFF_FFFC;
            va   = $urandom;
            setup_rand(va, base);
            walk(va, base, 1'($urandom % 2), 3'($urandom % 8), 1'($urandom % 4 == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule